// File: doc/BRIEF.md
# Raster Position Interrupt with Cycle-Exact Exit

This block raises a CPU interrupt at a programmed screen position on a console whose picture processor advances three dots for every CPU cycle. It tracks the beam as one linear dot position, advanced by a dot tick and returned to zero by a frame-start pulse. Software places the target through two 8-bit registers. The horizontal target has half resolution. The vertical target uses a folded code that cannot name the first lines of vblank.

The interrupt line rises a fixed fourteen CPU cycles before the target. The time the CPU takes to enter its handler varies, so the block then counts CPU cycles from the moment the line rose. The surrounding glue places the block's delay byte on the data bus whenever the handler fetches from a delay window. Each fetch sees either a two-cycle filler, a three-cycle filler or an exit code, chosen from the cycles that remain. The handler therefore leaves the window on the target cycle, and the remaining error is the three dots that make up one CPU cycle.

Top module: `raster_irq`

## Requirements
- R1: The beam position advances by one on each `dot_tick`. After the last dot of a frame (341 × 262 − 1 = 89341) it wraps to 0. `frame_start` forces it to 0 and takes precedence over `dot_tick`.
- R2: The horizontal target is stored at half resolution: a value X selects dot 2·X of the target line, and the position may run past the end of that line.
- R3: The vertical code Y selects the target line as follows: Y 0–239 selects line Y, Y 255 selects line 240, and Y 240–254 selects lines 247–261. Lines 241–246 cannot be selected.
- R4: `irq` rises on the advance that puts the position at the target minus 42 dots (14 CPU cycles × 3). When that value falls before 0 it wraps to the end of the previous frame, and when it falls past the frame end it wraps to the start.
- R5: `irq` is a level. It stays high until a write to register address 2 (acknowledge, data ignored), which clears it in the next cycle. A firing in the same cycle as an acknowledge wins.
- R6: A write to address 0 (X) or address 1 (Y) clears `irq` and suppresses any firing in that same cycle.
- R7: Out of reset `irq` is low and `slide_data` shows the exit code.
- R8: The delay byte depends on r = 14 − c, where c is the number of `cpu_cycle` strobes since `irq` last rose. The count is reset on each firing, saturates at 255 and is 255 out of reset. The byte is 0x24 (three-cycle filler) when r = 3, 0x60 (exit) when r ≤ 1, and 0xEA (two-cycle filler) otherwise.
- R9: A handler that makes its first window fetch at any cycle L ≤ 12 after the rise, then runs the fillers for their lengths, fetches the exit code at exactly cycle 14. For L ≥ 13 it exits at L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Pulse returning the beam position to 0 |
| dot_tick | input | 1 | One-cycle strobe per picture dot |
| cpu_cycle | input | 1 | One-cycle strobe per CPU cycle |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 = X target, 1 = Y target, 2 = acknowledge |
| reg_wdata | input | 8 | Register write data |
| irq | output | 1 | Level interrupt request |
| slide_data | output | 8 | Delay byte for fetches from the window |

## Verification
Random X values over the full byte, with Y on the first lines of the frame, test the half-resolution scaling and the 42-dot lead one dot at a time. Any off-by-one in the multiply or the lead shows up as a firing one tick early or late. One continuous frame is then walked with Y set to 255, 240, 254 and 0 in turn, plus a target exactly 42 dots in. This separates the folded line mapping and both wrap directions from the plain case. A sweep of handler entry latencies from 0 to 20 cycles runs a CPU model through the delay window and separates the parity fix (the three-cycle filler) from the saturating exit.

// File: rtl/raster_irq.sv
module raster_irq #(
  parameter int DOTS         = 341,
  parameter int LINES        = 262,
  parameter int VIS          = 240,
  parameter int VB_SKIP      = 6,
  parameter int LEAD_CYC     = 14,
  parameter int DOTS_PER_CYC = 3,
  parameter logic [7:0] OP_FILL2 = 8'hEA,
  parameter logic [7:0] OP_FILL3 = 8'h24,
  parameter logic [7:0] OP_EXIT  = 8'h60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic       dot_tick,
  input  logic       cpu_cycle,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic       irq,
  output logic [7:0] slide_data
);
  localparam int FRAME = DOTS * LINES;
  localparam int PW    = $clog2(FRAME);
  localparam int WW    = PW + 2;
  localparam logic [WW-1:0] FRAME_W = WW'(FRAME);
  localparam logic [WW-1:0] DOTS_W  = WW'(DOTS);
  localparam logic [WW-1:0] LEAD_W  = WW'(LEAD_CYC * DOTS_PER_CYC);
  localparam logic [PW-1:0] LAST    = PW'(FRAME - 1);
  localparam logic [7:0] LEAD8 = 8'(LEAD_CYC);
  localparam logic [7:0] L1    = 8'(LEAD_CYC - 1);
  localparam logic [7:0] L3    = 8'(LEAD_CYC - 3);

  logic [PW-1:0] pos, pos_next;
  logic [7:0]    tx, ty, cyc;
  logic [8:0]    tline;
  logic [WW-1:0] tgt, tdiff, fire_pos;
  logic          adv, fire, wr_tgt, wr_ack;

  assign adv      = frame_start | dot_tick;
  assign pos_next = frame_start ? '0 : ((pos == LAST) ? '0 : pos + 1'b1);
  assign wr_tgt   = reg_we && (reg_addr == 2'd0 || reg_addr == 2'd1);
  assign wr_ack   = reg_we && reg_addr == 2'd2;

  always_comb begin
    if (ty < 8'(VIS))        tline = {1'b0, ty};
    else if (ty == 8'hFF)    tline = 9'(VIS);
    else                     tline = {1'b0, ty} + 9'(VB_SKIP + 1);
  end

  always_comb begin
    tgt   = WW'(tline) * DOTS_W + WW'({tx, 1'b0});
    tdiff = tgt - LEAD_W;
    if (tgt < LEAD_W)          fire_pos = tgt + FRAME_W - LEAD_W;
    else if (tdiff >= FRAME_W) fire_pos = tdiff - FRAME_W;
    else                       fire_pos = tdiff;
  end

  assign fire = adv && (WW'(pos_next) == fire_pos) && !wr_tgt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0;
      tx  <= '0;
      ty  <= '0;
      irq <= 1'b0;
      cyc <= 8'hFF;
    end else begin
      if (adv) pos <= pos_next;
      if (reg_we && reg_addr == 2'd0) tx <= reg_wdata;
      if (reg_we && reg_addr == 2'd1) ty <= reg_wdata;
      if (wr_tgt)      irq <= 1'b0;
      else if (fire)   irq <= 1'b1;
      else if (wr_ack) irq <= 1'b0;
      if (fire)                         cyc <= '0;
      else if (cpu_cycle && cyc != 8'hFF) cyc <= cyc + 1'b1;
    end
  end

  always_comb begin
    if (cyc >= LEAD8 || cyc == L1) slide_data = OP_EXIT;
    else if (cyc == L3)            slide_data = OP_FILL3;
    else                           slide_data = OP_FILL2;
  end

  // R1
  pos_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> pos == '0);
  // R1
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= LAST);
  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && !fire) |=> !irq);
  // R5
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !reg_we) |=> irq);
  // R6
  tgt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tgt |=> !irq);
  // R8
  cyc_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> cyc == '0);
  // R8
  late_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc >= LEAD8 |-> slide_data == OP_EXIT);
endmodule

// File: tb/raster_irq_bench.sv
`timescale 1ns/1ps
module raster_irq_bench;
  localparam int FRAME = 341 * 262;
  localparam int LEAD  = 42;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_start = 1'b0, dot_tick = 1'b0, cpu_cycle = 1'b0, reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic irq;
  logic [7:0] slide_data;

  int checks = 0, failures = 0;
  int bpos = 0, bx = 0, by = 0;
  logic bpend = 1'b0;
  bit done = 1'b0;

  raster_irq u_raster_irq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .dot_tick(dot_tick),
    .cpu_cycle(cpu_cycle), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .irq(irq), .slide_data(slide_data));

  always #4 clk = ~clk;

  function automatic int line_of(int y);
    if (y < 240) return y;
    if (y == 255) return 240;
    return y + 7;
  endfunction

  function automatic int fire_of(int x, int y);
    int t = line_of(y) * 341 + 2 * x;
    if (t < LEAD) return t + FRAME - LEAD;
    if (t - LEAD >= FRAME) return t - LEAD - FRAME;
    return t - LEAD;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(bit fs, bit dt, bit cc);
    @(negedge clk);
    frame_start = fs; dot_tick = dt; cpu_cycle = cc;
    @(posedge clk); #2;
    frame_start = 0; dot_tick = 0; cpu_cycle = 0;
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_we = 1; reg_addr = 2'(a); reg_wdata = 8'(d);
    @(posedge clk); #2;
    reg_we = 0;
    if (a == 0) bx = d;
    if (a == 1) by = d;
    if (a <= 2) bpend = 1'b0;
  endtask

  task automatic run_dots(int n, bit fs_first, string req);
    int bad = 0, act = 0, exp = 0;
    for (int i = 0; i < n; i++) begin
      bit fs = fs_first && i == 0;
      step(fs, !fs, 1'b0);
      bpos = fs ? 0 : ((bpos == FRAME - 1) ? 0 : bpos + 1);
      if (bpos == fire_of(bx, by)) bpend = 1'b1;
      if (irq !== bpend && bad == 0) begin bad = 1; act = bpos; exp = int'(bpend); end
    end
    chk(bad == 0, req, act, exp);
  endtask

  task automatic slide_run(int lat);
    int c = 0, ex = -1, expx;
    wr(0, 21); wr(1, 0);
    step(1'b1, 1'b0, 1'b0); bpos = 0;
    chk(irq === 1'b1, "R4 lead wrap to 0", int'(irq), 1);
    for (int i = 0; i < lat; i++) begin step(0, 0, 1); c++; end
    for (int k = 0; k < 40 && ex < 0; k++) begin
      if (slide_data == 8'h60) ex = c;
      else if (slide_data == 8'hEA) begin step(0, 0, 1); step(0, 0, 1); c += 2; end
      else if (slide_data == 8'h24) begin step(0, 0, 1); step(0, 0, 1); step(0, 0, 1); c += 3; end
      else begin chk(0, "R8 code", int'(slide_data), 96); ex = c; end
    end
    expx = (lat >= 13) ? lat : 14;
    chk(ex == expx, "R9 exit cycle", ex, expx);
    wr(2, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(irq === 1'b0, "R7 reset irq", int'(irq), 0);
    chk(slide_data == 8'h60, "R7 reset code", int'(slide_data), 96);

    // R2 R4 random targets on early lines
    for (int t = 0; t < 12; t++) begin
      int x = int'($urandom % 256), y = int'($urandom % 4);
      wr(0, x); wr(1, y);
      run_dots(fire_of(x, y) + 4, 1'b1, "R2 R4 random fire");
      chk(irq === 1'b1, "R4 fired", int'(irq), 1);
      // R5 level holds through more dots, then ack clears
      run_dots(3, 1'b0, "R5 hold");
      wr(2, 8'h5A);
      chk(irq === 1'b0, "R5 ack", int'(irq), 0);
    end

    // R6: writing target clears pending
    wr(0, 30); wr(1, 0);
    run_dots(fire_of(30, 0) + 2, 1'b1, "R4 fire");
    wr(0, 31);
    chk(irq === 1'b0, "R6 X write clears", int'(irq), 0);

    // R3 R1 long frame walk with folded Y codes and wraps
    wr(0, 0); wr(1, 255);
    run_dots(fire_of(0, 255) + 3, 1'b1, "R3 Y255 line 240");
    wr(1, 240);
    run_dots(fire_of(0, 240) - bpos + 3, 1'b0, "R3 Y240 line 247");
    wr(1, 254);
    run_dots(fire_of(0, 254) - bpos + 3, 1'b0, "R3 Y254 line 261");
    wr(1, 0);
    run_dots(FRAME - bpos + 5, 1'b0, "R1 R4 wrap to prev frame end");
    chk(irq === 1'b1 && bpos == 5, "R1 wrap pending", int'(irq), 1);
    wr(2, 0);

    // R8 R9 latency sweep
    for (int l = 0; l <= 20; l++) slide_run(l);

    // R8 saturation after many cycles
    for (int i = 0; i < 260; i++) step(0, 0, 1);
    chk(slide_data == 8'h60, "R8 saturated exit", int'(slide_data), 96);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule